// File: doc/BRIEF.md
# Key-Gated Programming Control Register

This block guards a small programming control register behind a two-step unlock. Out of reset the register cannot be written. Software first writes a fixed pair of bytes, in a fixed order, to a separate unlock register. Only then do writes to the control register take effect. Any other byte written to the unlock register locks the control register again at once. The block sits on a simple byte-wide register bus made of address, write strobe, write data and a combinational read path.

The control register drives three outputs. One enables the auxiliary on-chip RAM. One selects the loader bank as the boot source. The third flags that programming is wanted, and programming mode then becomes active on the next wakeup from idle, which arrives as a one-cycle input pulse. A write that sets bits 7, 1 and 0 together asks for a software reset. The block answers with a one-cycle request pulse and returns the register to its reset state.

While reset is held, the block also samples three active-low strap pins. If they call for a forced boot from the loader, that fact can be read back in bit 7 of the control register. In that mode the software-reset pattern has no reset effect.

Top module: `isp_keyed_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, the control register reads bits 6..0 as 0. The auxiliary-RAM enable, loader select, programming-active and software-reset outputs are all low.
- R2: A write to the control register before any unlock changes neither its read value nor any output.
- R3: After the unlock register receives 87h and then 59h, a control register write stores bits 4, 1 and 0. Bits 6, 5, 3 and 2 always read back as 0.
- R4: Writing any byte other than 87h or 59h to the unlock register relocks it, and the next control register write is ignored.
- R5: A 59h that arrives without a preceding 87h does not unlock. Once unlocked, the block stays unlocked across any number of control register writes.
- R6: `aux_ram_en` equals stored bit 4, `loader_sel` equals stored bit 1 and `prog_en` equals stored bit 0. Each changes in the cycle after the accepted write.
- R7: `prog_active` rises only in the cycle after an `idle_wake` pulse that arrives while bit 0 is set. It falls in the same cycle in which bit 0 is cleared. A wake pulse while bit 0 is clear has no effect.
- R8: An unlocked write with bits 7, 1 and 0 all set, made while not in forced-boot mode, raises `sw_reset_req` for exactly one cycle, starting in the cycle after the write. In that same cycle the stored bits read 0 and the register is locked again.
- R9: Forced-boot mode is captured during reset when `strap_a_n` and `strap_b_n` are both low, or when `strap_c_n` is low. In that mode bit 7 reads 1, and a write of the reset pattern gives no pulse and is stored as an ordinary write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| strap_a_n | input | 1 | Boot strap A, active low |
| strap_b_n | input | 1 | Boot strap B, active low |
| strap_c_n | input | 1 | Boot strap C, active low |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (unlock register reads 0) |
| idle_wake | input | 1 | One-cycle pulse marking a wakeup from idle |
| aux_ram_en | output | 1 | Auxiliary RAM enable |
| loader_sel | output | 1 | Loader bank boot select |
| prog_en | output | 1 | Programming requested |
| prog_active | output | 1 | Programming mode active |
| sw_reset_req | output | 1 | One-cycle software reset request |

## Verification
A stuck or wrongly sequenced unlock state shows up in the first control register write that follows the key writes. That write is then either wrongly accepted or wrongly dropped, and the error is visible on the read data and on the enable outputs one cycle later. A wrong forced-boot capture changes bit 7 right after reset. It also changes whether the reset pattern produces a pulse in the cycle after the write. A `prog_active` flag that is not cleared together with bit 0 is visible in the same cycle as the clearing write.

// File: rtl/isp_keyed_ctrl.sv
module isp_keyed_ctrl #(
  parameter int          AW         = 8,
  parameter logic [AW-1:0] KEY_ADDR   = 8'h40,
  parameter logic [AW-1:0] CTRL_ADDR  = 8'h41,
  parameter logic [7:0]  KEY_FIRST  = 8'h87,
  parameter logic [7:0]  KEY_SECOND = 8'h59
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strap_a_n,
  input  logic          strap_b_n,
  input  logic          strap_c_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          idle_wake,
  output logic          aux_ram_en,
  output logic          loader_sel,
  output logic          prog_en,
  output logic          prog_active,
  output logic          sw_reset_req
);

  logic boot_forced, wr_open, armed;
  logic aux_q, ldr_q, prg_q, pact_q, swr_q;
  logic aux_d, ldr_d, prg_d;
  logic key_wr, ctrl_wr, swr_hit, key_ok;

  assign key_wr  = bus_we && (bus_addr == KEY_ADDR);
  assign ctrl_wr = bus_we && (bus_addr == CTRL_ADDR) && wr_open;
  assign swr_hit = ctrl_wr && bus_wdata[7] && bus_wdata[1] && bus_wdata[0] && !boot_forced;
  assign key_ok  = (bus_wdata == KEY_FIRST) || (bus_wdata == KEY_SECOND);

  always_comb begin
    {aux_d, ldr_d, prg_d} = {aux_q, ldr_q, prg_q};
    if (swr_hit)      {aux_d, ldr_d, prg_d} = 3'b000;
    else if (ctrl_wr) {aux_d, ldr_d, prg_d} = {bus_wdata[4], bus_wdata[1], bus_wdata[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_forced <= (!strap_a_n && !strap_b_n) || !strap_c_n;
      {aux_q, ldr_q, prg_q} <= 3'b000;
      pact_q  <= 1'b0;
      swr_q   <= 1'b0;
      wr_open <= 1'b0;
      armed   <= 1'b0;
    end else begin
      {aux_q, ldr_q, prg_q} <= {aux_d, ldr_d, prg_d};
      pact_q <= prg_d && (pact_q || (idle_wake && prg_q));
      swr_q  <= swr_hit;
      if (swr_hit) begin
        wr_open <= 1'b0;
        armed   <= 1'b0;
      end else if (key_wr) begin
        if (bus_wdata == KEY_FIRST) begin
          armed <= 1'b1;
        end else if (bus_wdata == KEY_SECOND) begin
          if (armed) wr_open <= 1'b1;
          armed <= 1'b0;
        end else begin
          wr_open <= 1'b0;
          armed   <= 1'b0;
        end
      end
    end
  end

  assign bus_rdata    = (bus_addr == CTRL_ADDR) ? {boot_forced, 2'b00, aux_q, 2'b00, ldr_q, prg_q} : 8'h00;
  assign aux_ram_en   = aux_q;
  assign loader_sel   = ldr_q;
  assign prog_en      = prg_q;
  assign prog_active  = pact_q;
  assign sw_reset_req = swr_q;

  assert_locked_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == CTRL_ADDR && !wr_open) |=> $stable({aux_q, ldr_q, prg_q}));

  assert_relock_R4: assert property (@(posedge clk) disable iff (rst)
    (key_wr && !key_ok) |=> !wr_open);

  assert_open_only_after_key_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_open) |-> $past(key_wr && bus_wdata == KEY_SECOND && armed));

  assert_prog_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pact_q) |-> $past(idle_wake && prg_q));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    sw_reset_req |=> !sw_reset_req);

  assert_pulse_clears_R8: assert property (@(posedge clk) disable iff (rst)
    sw_reset_req |-> ({aux_q, ldr_q, prg_q} == 3'b000 && !wr_open && !pact_q));

  assert_forced_no_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    boot_forced |-> !sw_reset_req);

endmodule

// File: tb/sim_isp_keyed_ctrl.sv
module sim_isp_keyed_ctrl;
  localparam logic [7:0] KA = 8'h40;
  localparam logic [7:0] CA = 8'h41;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sa = 1'b1, sb = 1'b1, sc = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic idle_wake = 1'b0;
  logic aux_ram_en, loader_sel, prog_en, prog_active, sw_reset_req;

  always #4 clk = ~clk;

  isp_keyed_ctrl u0 (
    .clk(clk), .rst(rst), .strap_a_n(sa), .strap_b_n(sb), .strap_c_n(sc),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .idle_wake(idle_wake), .aux_ram_en(aux_ram_en), .loader_sel(loader_sel),
    .prog_en(prog_en), .prog_active(prog_active), .sw_reset_req(sw_reset_req)
  );

  typedef struct {
    logic [12:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  logic chk_req = 1'b0;
  logic done = 1'b0;

  // observed vector: {pulse, prog_active, prog_en, loader_sel, aux_ram_en, rdata}
  always @(negedge clk) begin
    if (chk_req && sb_q.size() > 0) begin
      item_t it;
      logic [12:0] obs;
      it  = sb_q.pop_front();
      obs = {sw_reset_req, prog_active, prog_en, loader_sel, aux_ram_en, bus_rdata};
      checks++;
      if (obs !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, obs, it.exp);
      end
    end
  end

  task automatic expect_ctrl(input logic pulse, input logic pact, input logic [7:0] rd, input string tag);
    item_t it;
    it.exp = {pulse, pact, rd[0], rd[1], rd[4], rd};
    it.tag = tag;
    bus_addr = CA;
    sb_q.push_back(it);
    chk_req = 1'b1;
    @(negedge clk);
    #1 chk_req = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic unlock();
    wr(KA, 8'h87);
    wr(KA, 8'h59);
  endtask

  task automatic wake();
    @(posedge clk); #1 idle_wake = 1'b1;
    @(posedge clk); #1 idle_wake = 1'b0;
  endtask

  task automatic do_reset(input logic a, input logic b, input logic c);
    @(posedge clk); #1;
    sa = a; sb = b; sc = c; rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    sa = 1'b1; sb = 1'b1; sc = 1'b1;
  endtask

  initial begin
    do_reset(1'b1, 1'b1, 1'b1);
    expect_ctrl(0, 0, 8'h00, "R1 reset state");

    wr(CA, 8'h13);
    expect_ctrl(0, 0, 8'h00, "R2 write before unlock ignored");

    wr(KA, 8'h59);
    wr(CA, 8'h13);
    expect_ctrl(0, 0, 8'h00, "R5 lone second key does not unlock");

    unlock();
    wr(CA, 8'h7E);
    expect_ctrl(0, 0, 8'h12, "R3 R6 accepted write, reserved bits read 0");

    wr(CA, 8'h01);
    expect_ctrl(0, 0, 8'h01, "R5 stays unlocked on second write");

    wake();
    expect_ctrl(0, 1, 8'h01, "R7 wake with bit0 set activates");

    wr(KA, 8'h12);
    wr(CA, 8'h10);
    expect_ctrl(0, 1, 8'h01, "R4 wrong key relocks");

    wr(KA, 8'h87); wr(KA, 8'h87); wr(KA, 8'h59);
    wr(CA, 8'h00);
    expect_ctrl(0, 0, 8'h00, "R7 clearing bit0 drops active same cycle");

    wake();
    expect_ctrl(0, 0, 8'h00, "R7 wake with bit0 clear ignored");

    wr(CA, 8'h12);
    expect_ctrl(0, 0, 8'h12, "R6 loader and aux follow bits");
    wr(CA, 8'h83);
    expect_ctrl(1, 0, 8'h00, "R8 reset pattern pulses and clears");
    @(posedge clk); #1;
    expect_ctrl(0, 0, 8'h00, "R8 pulse lasts one cycle");
    wr(CA, 8'h10);
    expect_ctrl(0, 0, 8'h00, "R8 relocked after software reset");

    do_reset(1'b0, 1'b0, 1'b1);
    expect_ctrl(0, 0, 8'h80, "R9 forced boot via straps a and b");
    unlock();
    wr(CA, 8'h83);
    expect_ctrl(0, 0, 8'h83, "R9 reset pattern ignored in forced boot");

    do_reset(1'b1, 1'b1, 1'b0);
    expect_ctrl(0, 0, 8'h80, "R9 forced boot via strap c");

    do_reset(1'b0, 1'b1, 1'b1);
    expect_ctrl(0, 0, 8'h00, "R9 single strap a does not force");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule